// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host read and write an internal bank of byte-wide registers over a four-wire serial link. The link has an active-low select, a serial clock, a data line into the slave and a data line out of it. The slave runs entirely on its own fast system clock. It passes the three incoming serial lines through a synchroniser and finds serial clock edges by comparing successive synchronised samples. This works because each serial clock phase lasts at least three and a half system clock periods.

Every access moves one register and is framed by one low period of the select line. A transfer starts with a direction flag, where 1 means read and 0 means write. Seven address bits follow, lowest bit first, then eight data bits, also lowest bit first. For a write, the host supplies the data bits and the register is updated once the last of them has arrived. For a read, the slave fetches the register right after the address is complete and shifts it out. A static strap input chooses which serial clock edge launches read data. Incoming bits are always taken on the rising edge.

The output pin is described by a data bit and a separate pad enable. A tristate pad outside the block combines them, and the pin floats whenever the enable is low.

Top module: `ser_reg_slave`

## Requirements
- R1: A frame carries bit 0 = direction (1 read, 0 write), bits 1..7 = address A0..A6, and bits 8..15 = data D0..D7, all taken lowest bit first.
- R2: The direction, address and write data bits are all taken from the input line at rising serial clock edges, whichever launch edge is strapped.
- R3: A write frame updates the addressed register only after its 16th bit. A read frame never alters any register, whatever the host drives during its data bits.
- R4: If select goes high before 16 bits have arrived, no register is written and the next frame is decoded from its first bit.
- R5: With the strap low, read bit Dk is presented on the output after the (9+k)th rising serial clock edge.
- R6: With the strap high, read bit Dk is presented on the output after the (k+1)th falling serial clock edge that follows the 8th rising edge.
- R7: The pad enable is low throughout the header, and it is low within three system clocks of select going high.
- R8: After reset the pad enable is low.
- R9: Each select-low period transfers exactly one register, and consecutive frames are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| launch_on_fall | input | 1 | Strap: 0 launches read data on rising serial clock edges, 1 on falling edges |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the slave |
| sdo_d | output | 1 | Serial read data bit |
| sdo_oe | output | 1 | Pad enable for the serial output |

## Verification
A serial clock edge on the pins reaches the frame logic after the two synchroniser stages, and its effect is registered one cycle later. So any output change is due three system clocks after the pin edge. A read adds two further cycles, one for the fetch and one for the load, and both finish before the first launch edge can be detected. The bench holds every serial clock phase for six system clocks. It samples the data and pad enable on the last falling system clock edge of the phase that follows the launching edge, well past the three-cycle latency and before the next edge can act. After select rises it waits the same six clocks before checking that the enable has dropped.

// File: rtl/ser_slave_pkg.sv
package ser_slave_pkg;
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;

  function automatic dir_e dir_of(input logic flag);
    return flag ? DIR_READ : DIR_WRITE;
  endfunction
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ser_edge.sv
module ser_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  // one edge kind per cycle
  p_edge_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({rise, fall}) <= 1);
endmodule

// File: rtl/ser_regbank.sv
module ser_regbank #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/ser_frame.sv
module ser_frame
  import ser_slave_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          rise,
  input  logic          fall,
  input  logic          sdi_s,
  input  logic          launch_on_fall,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          sdo_d,
  output logic          sdo_oe
);
  localparam int HDR_W   = AW + 1;
  localparam int FRAME_W = HDR_W + DW;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [CNT_W-1:0] cnt;
  logic [HDR_W-1:0] hdr;
  logic [DW-1:0]    dat;
  logic [DW-1:0]    shreg;
  logic             hdr_done;
  logic             load_pend;
  logic             oe;

  logic launch, in_hdr, last_bit;
  dir_e dir;

  assign launch   = launch_on_fall ? fall : rise;
  assign in_hdr   = (cnt < CNT_HDR);
  assign last_bit = rise && (cnt == CNT_LAST);
  assign dir      = dir_of(hdr[0]);

  // R3: commit only on the final data bit of a write frame
  assign mem_we    = !cs_s && last_bit && (dir == DIR_WRITE);
  assign mem_en    = mem_we || (hdr_done && dir == DIR_READ);
  assign mem_addr  = hdr[HDR_W-1:1];
  assign mem_wdata = {sdi_s, dat[DW-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      hdr       <= '0;
      dat       <= '0;
      shreg     <= '0;
      hdr_done  <= 1'b0;
      load_pend <= 1'b0;
      oe        <= 1'b0;
    end else begin
      hdr_done  <= 1'b0;
      load_pend <= hdr_done && (dir == DIR_READ) && !cs_s;
      if (cs_s) begin
        // R4/R7: select high ends or aborts the frame
        cnt <= '0;
        oe  <= 1'b0;
      end else begin
        // R1/R2: capture on rising edges, lowest bit first
        if (rise && cnt != CNT_FULL) begin
          cnt <= cnt + 1'b1;
          if (in_hdr) hdr <= {sdi_s, hdr[HDR_W-1:1]};
          else        dat <= {sdi_s, dat[DW-1:1]};
          if (cnt == CNT_HDR - 1'b1) hdr_done <= 1'b1;
        end
        // R5/R6: first launch edge enables D0, later ones shift
        if (load_pend) begin
          shreg <= mem_rdata;
        end else if (launch && !in_hdr && dir == DIR_READ) begin
          if (!oe) oe <= 1'b1;
          else     shreg <= {1'b0, shreg[DW-1:1]};
        end
      end
    end
  end

  assign sdo_d  = shreg[0];
  assign sdo_oe = oe;

  p_oe_cs_r7: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_oe);
  p_oe_hdr_r7: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> (cnt >= CNT_HDR));
  p_cnt_clr_r4: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (cnt == '0));
  p_cnt_max_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);
  p_wr_single_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  p_rd_load_r1: assert property (@(posedge clk) disable iff (rst)
    load_pend |-> ($past(mem_en) && !$past(mem_we)));
endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic launch_on_fall,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo_d,
  output logic sdo_oe
);
  logic [2:0] sync_q;
  logic cs_s, sclk_s, sdi_s, rise, fall;
  logic mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  ser_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q(sync_q)
  );
  assign {cs_s, sclk_s, sdi_s} = sync_q;

  ser_edge #(.RST_VAL(1'b0)) u_edge (
    .clk(clk), .rst(rst), .lvl(sclk_s), .rise(rise), .fall(fall)
  );

  ser_frame #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .cs_s(cs_s), .rise(rise), .fall(fall),
    .sdi_s(sdi_s), .launch_on_fall(launch_on_fall),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sdo_d(sdo_d), .sdo_oe(sdo_oe)
  );

  ser_regbank #(.AW(ADDR_W), .DW(DATA_W)) u_bank (
    .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  p_reset_quiet_r8: assert property (@(posedge clk)
    $past(rst) |-> !sdo_oe);
endmodule

// File: tb/ser_reg_slave_tb.sv
module ser_reg_slave_tb;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic launch_on_fall = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi  = 1'b0;
  logic sdo_d, sdo_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] model [128];

  always #4 clk = ~clk;

  ser_reg_slave u_dut (
    .clk(clk), .rst(rst), .launch_on_fall(launch_on_fall),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo_d(sdo_d), .sdo_oe(sdo_oe)
  );

  // {fall_mode, rw, addr[6:0], data[7:0]}
  localparam int NV = 10;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b0, 7'h00, 8'hA5},
    {1'b0, 1'b0, 7'h7F, 8'h3C},
    {1'b0, 1'b0, 7'h2A, 8'h81},
    {1'b0, 1'b1, 7'h00, 8'h00},
    {1'b1, 1'b1, 7'h7F, 8'hFF},
    {1'b0, 1'b1, 7'h2A, 8'h00},
    {1'b1, 1'b0, 7'h2A, 8'h5E},
    {1'b1, 1'b1, 7'h2A, 8'h00},
    {1'b0, 1'b1, 7'h7F, 8'h00},
    {1'b1, 1'b1, 7'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic fall_mode, input logic rw,
                           input logic [6:0] a, input logic [7:0] d,
                           input int nbits, output logic [7:0] got,
                           output logic hdr_oe, output logic dat_oe_all,
                           output logic post_oe);
    got = '0; hdr_oe = 1'b0; dat_oe_all = 1'b1;
    launch_on_fall = fall_mode;
    sclk = 1'b0;
    repeat (H) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      if (i == 0)     b = rw;
      else if (i < 8) b = a[i-1];
      else            b = d[i-8];
      sclk = 1'b0; sdi = b;
      repeat (H) @(negedge clk);
      if (i < 8 && sdo_oe) hdr_oe = 1'b1;
      if (i >= 8 && fall_mode) begin got[i-8] = sdo_d; if (!sdo_oe) dat_oe_all = 1'b0; end
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (i < 8 && sdo_oe) hdr_oe = 1'b1;
      if (i >= 8 && !fall_mode) begin got[i-8] = sdo_d; if (!sdo_oe) dat_oe_all = 1'b0; end
    end
    sclk = 1'b0;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (H) @(negedge clk);
    post_oe = sdo_oe;
    if (rw == 1'b0 && nbits == 16) model[a] = d;
  endtask

  initial begin
    logic [7:0] got;
    logic hoe, doe, poe;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset pad enable", sdo_oe, 0);

    for (int v = 0; v < NV; v++) begin
      logic fm, rw;
      logic [6:0] a;
      logic [7:0] d;
      {fm, rw, a, d} = VEC[v];
      run_frame(fm, rw, a, d, 16, got, hoe, doe, poe);
      chk("R7 enable low in header", hoe, 0);
      chk("R7 enable low after select", poe, 0);
      if (rw) begin
        chk("R1 R2 read value", got, model[a]);
        if (fm) chk("R6 falling launch enable", doe, 1);
        else    chk("R5 rising launch enable", doe, 1);
      end
    end

    // R4: aborted write leaves register untouched
    run_frame(1'b0, 1'b0, 7'h2A, 8'hFF, 12, got, hoe, doe, poe);
    chk("R4 abort enable low", poe, 0);
    run_frame(1'b0, 1'b1, 7'h2A, 8'h00, 16, got, hoe, doe, poe);
    chk("R4 abort no write", got, 8'h5E);

    // R4: aborted read drops the enable
    run_frame(1'b1, 1'b1, 7'h7F, 8'h00, 10, got, hoe, doe, poe);
    chk("R4 abort read enable low", poe, 0);

    // R9: back-to-back independent frames
    run_frame(1'b0, 1'b0, 7'h01, 8'h55, 16, got, hoe, doe, poe);
    run_frame(1'b0, 1'b0, 7'h02, 8'hC3, 16, got, hoe, doe, poe);
    run_frame(1'b1, 1'b1, 7'h01, 8'h00, 16, got, hoe, doe, poe);
    chk("R9 first of pair", got, 8'h55);
    run_frame(1'b0, 1'b1, 7'h02, 8'h00, 16, got, hoe, doe, poe);
    chk("R9 second of pair", got, 8'hC3);

    // R3: read frame with ones on the data line does not write
    run_frame(1'b0, 1'b1, 7'h01, 8'hFF, 16, got, hoe, doe, poe);
    run_frame(1'b0, 1'b1, 7'h01, 8'h00, 16, got, hoe, doe, poe);
    chk("R3 read leaves register", got, 8'h55);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule